// File: doc/BRIEF.md
# SPI Memory Identification Probe

This block works out which serial memory sits on an SPI bus at startup. On a start pulse it opens a chip-select frame and sends the read-identification opcode. It then clocks in identification bytes. Leading continuation bytes are discarded. The first real byte is taken as the manufacturer code. When that code names the supported vendor, the next two bytes are matched against a built-in table of six devices. The probe reports whether a device was found, the table index, the memory size in bytes and the number of address bytes the device expects.

A bus with nothing driving the data-in line reads all ones, so a manufacturer code of 0xFF cannot be trusted. In that case the probe closes the frame and opens a second one to read the status register. It accepts a configured default device only when the status bits that are always zero on such memories really are zero. This check can give a false positive, so it is the last path the probe tries. Bit-level shifting is left to an external byte-exchange engine. The probe hands that engine one byte at a time and takes back the byte received in the same exchange.

Top module: `spi_mem_probe`

## Requirements
- R1: After reset, `cs_n` is 1, `xfer_req` is 0, `done` is 0 and `found` is 0.
- R2: The ID frame holds `cs_n` low for the whole frame. It sends opcode 0x9F first, then transmits 0x00 on every following byte exchange.
- R3: Received bytes equal to 0x7F are skipped, up to MAX_CONT of them (8 by default). A further 0x7F ends the probe with not-found.
- R4: A manufacturer byte of 0xC2 causes two more bytes, ID1 and ID2, to be read. The pair maps to an index as follows: 0x22/0x00 gives 0 and 0x22/0x01 gives 1, both 32768 bytes with 2 address bytes. 0x23/0x00 gives 2 and 0x23/0x01 gives 3, both 65536 bytes with 2 address bytes. 0x24/0x00 gives 4 and 0x24/0x01 gives 5, both 131072 bytes with 3 address bytes.
- R5: A 0xC2 manufacturer byte followed by an ID pair that is not in the table gives not-found.
- R6: Any manufacturer byte other than 0xC2 or 0xFF gives not-found, and the frame closes after that byte.
- R7: If the manufacturer byte is 0xFF and the fallback is enabled, `cs_n` goes high for at least one cycle. A new frame then sends opcode 0x05 and reads one status byte.
- R8: The fallback succeeds only when (status AND 0x31) equals 0. Success gives found with index 6, 262144 bytes and 3 address bytes. Otherwise the result is not-found.
- R9: `done` is a single-cycle pulse. The result outputs are cleared at start and hold their value from `done` until the next start. A not-found result reports index, size and address bytes as 0.
- R10: A `start` pulse that arrives while a probe is running is ignored.
- R11: `xfer_req` stays high and `xfer_tx` stays stable until `xfer_ack` completes the byte exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; ignored while busy |
| xfer_req | output | 1 | Byte exchange request |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | One-cycle completion of a byte exchange |
| xfer_rx | input | 8 | Byte received, valid with xfer_ack |
| cs_n | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle end-of-probe pulse |
| found | output | 1 | A supported device was identified |
| entry_idx | output | IDX_W | Matched table index, 6 for the default device |
| mem_bytes | output | SIZE_W | Memory size in bytes |
| addr_bytes | output | 2 | Address bytes used by the device |

## Verification
Some properties are checked on every cycle. These are that `done` never lasts two cycles, that results stay still while the probe is idle, that an unanswered byte request holds its data, that the continuation counter never passes its limit, and that the status frame always follows a chip-select gap. Other behaviour can only be shown by the bench scenarios, each driven through a byte-exchange responder. These cover the table lookup for each ID pair, rejection of unknown pairs and vendors, the exact continuation limit, and acceptance or rejection by the status mask. The bench also confirms the exact opcode and dummy-byte order, and that a start pulse during a probe changes nothing.

// File: rtl/spi_mem_probe.sv
module spi_mem_probe #(
  parameter int MAX_CONT    = 8,
  parameter bit FALLBACK_EN = 1'b1,
  parameter int DEF_BYTES   = 262144,
  parameter int DEF_ADDR    = 3,
  parameter int SIZE_W      = 24,
  parameter int IDX_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              cs_n,
  output logic              done,
  output logic              found,
  output logic [IDX_W-1:0]  entry_idx,
  output logic [SIZE_W-1:0] mem_bytes,
  output logic [1:0]        addr_bytes
);
  localparam int CNT_W   = $clog2(MAX_CONT + 1);
  localparam int NUM_TAB = 6;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] MFR_OK  = 8'hC2;
  localparam logic [7:0] CONT_B  = 8'h7F;

  typedef enum logic [3:0] {
    S_IDLE, S_OP, S_ID, S_D1, S_D2, S_GAP, S_SOP, S_SRD
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cont_q;
  logic [7:0]       id1_q;

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [SIZE_W-1:0] hit_size;
  logic [1:0]        hit_addr;

  assign xfer_req = (state == S_OP) || (state == S_ID) || (state == S_D1) ||
                    (state == S_D2) || (state == S_SOP) || (state == S_SRD);
  assign cs_n     = !xfer_req;
  assign xfer_tx  = (state == S_OP)  ? OP_RDID :
                    (state == S_SOP) ? OP_RDSR : 8'h00;

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    hit_size = '0;
    hit_addr = 2'd0;
    for (int i = 0; i < NUM_TAB; i++) begin
      if (id1_q == 8'(8'h22 + i / 2) && xfer_rx == 8'(i % 2)) begin
        hit      = 1'b1;
        hit_idx  = IDX_W'(i);
        hit_size = SIZE_W'(32'd32768 << (i / 2));
        hit_addr = (i >= 4) ? 2'd3 : 2'd2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cont_q     <= '0;
      id1_q      <= '0;
      done       <= 1'b0;
      found      <= 1'b0;
      entry_idx  <= '0;
      mem_bytes  <= '0;
      addr_bytes <= 2'd0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state      <= S_OP;
          cont_q     <= '0;
          found      <= 1'b0;
          entry_idx  <= '0;
          mem_bytes  <= '0;
          addr_bytes <= 2'd0;
        end
        S_OP: if (xfer_ack) state <= S_ID;
        S_ID: if (xfer_ack) begin
          if (xfer_rx == CONT_B) begin
            if (cont_q == CNT_W'(MAX_CONT)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              cont_q <= cont_q + 1'b1;
            end
          end else if (xfer_rx == MFR_OK) begin
            state <= S_D1;
          end else if (xfer_rx == 8'hFF && FALLBACK_EN) begin
            state <= S_GAP;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_D1: if (xfer_ack) begin
          id1_q <= xfer_rx;
          state <= S_D2;
        end
        S_D2: if (xfer_ack) begin
          state <= S_IDLE;
          done  <= 1'b1;
          if (hit) begin
            found      <= 1'b1;
            entry_idx  <= hit_idx;
            mem_bytes  <= hit_size;
            addr_bytes <= hit_addr;
          end
        end
        S_GAP: state <= S_SOP;
        S_SOP: if (xfer_ack) state <= S_SRD;
        S_SRD: if (xfer_ack) begin
          state <= S_IDLE;
          done  <= 1'b1;
          if ((xfer_rx & 8'h31) == 8'h00) begin
            found      <= 1'b1;
            entry_idx  <= IDX_W'(NUM_TAB);
            mem_bytes  <= SIZE_W'(DEF_BYTES);
            addr_bytes <= 2'(DEF_ADDR);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start) |=> ($stable(found) && $stable(entry_idx) &&
                                     $stable(mem_bytes) && $stable(addr_bytes)));

  p_cont_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cont_q <= CNT_W'(MAX_CONT));

  p_gap_before_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SOP && !$past(state == S_SOP)) |-> $past(cs_n));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && state != S_OP && start) |=> state != S_OP);

  p_found_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (mem_bytes != '0 && addr_bytes >= 2'd2));
endmodule

// File: tb/spi_mem_probe_tb_top.sv
module spi_mem_probe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        xfer_req;
  logic [7:0]  xfer_tx;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'h00;
  logic        cs_n, done, found;
  logic [2:0]  entry_idx;
  logic [23:0] mem_bytes;
  logic [1:0]  addr_bytes;

  always #10 clk = ~clk;

  spi_mem_probe dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .cs_n(cs_n), .done(done), .found(found), .entry_idx(entry_idx),
    .mem_bytes(mem_bytes), .addr_bytes(addr_bytes)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int  wait_n = 0;
  bit  cs_gap = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) cs_gap = 1'b1;
      if (xfer_ack) begin
        xfer_ack = 1'b0;
        wait_n = 0;
      end else if (xfer_req) begin
        wait_n++;
        if (wait_n == 2) begin
          logic [7:0] e;
          if (txq.size() == 0) begin
            chk(0, "R2", "unexpected byte exchange", xfer_tx, 0);
            e = 8'h00;
          end else begin
            e = txq.pop_front();
            chk(xfer_tx == e, "R2", "tx byte", xfer_tx, e);
          end
          if (e == 8'h9F || e == 8'h05) begin
            chk(cs_gap, "R7", "new frame after cs high", cs_gap, 1);
            cs_gap = 1'b0;
            xfer_rx = 8'hFF;
          end else begin
            chk(!cs_gap, "R2", "cs held low in frame", cs_gap, 0);
            xfer_rx = (rxq.size() != 0) ? rxq.pop_front() : 8'hFF;
          end
          xfer_ack = 1'b1;
        end
      end
    end
  end

  bit          pending = 1'b0;
  bit          e_found, h_found;
  int          e_idx, e_size, e_addr, h_idx, h_size, h_addr;
  logic        prev_done = 1'b0;

  always begin
    @(posedge clk);
    #5;
    if (rst_n) begin
      if (done && prev_done) chk(0, "R9", "done longer than one cycle", 1, 0);
      if (done) begin
        chk(pending, "R9", "done without probe", 0, 1);
        chk(found == e_found, "R4", "found", found, e_found);
        chk(entry_idx == e_idx, "R4", "index", entry_idx, e_idx);
        chk(mem_bytes == e_size, "R4", "size", mem_bytes, e_size);
        chk(addr_bytes == e_addr, "R4", "addr bytes", addr_bytes, e_addr);
        h_found = e_found; h_idx = e_idx; h_size = e_size; h_addr = e_addr;
        pending = 1'b0;
      end else begin
        chk(found == h_found && entry_idx == h_idx && mem_bytes == h_size &&
            addr_bytes == h_addr, "R9", "held result",
            {found, entry_idx, mem_bytes}, {h_found, h_idx[2:0], h_size[23:0]});
      end
      prev_done = done;
    end
  end

  function automatic void set_tx(int n_id, bit status);
    txq = {};
    txq.push_back(8'h9F);
    for (int i = 0; i < n_id; i++) txq.push_back(8'h00);
    if (status) begin
      txq.push_back(8'h05);
      txq.push_back(8'h00);
    end
  endfunction

  task automatic run(string req, bit f, int idx, int sz, int ab, bit poke);
    int n;
    e_found = f; e_idx = idx; e_size = sz; e_addr = ab;
    @(negedge clk);
    start = 1'b1;
    pending = 1'b1;
    h_found = 0; h_idx = 0; h_size = 0; h_addr = 0;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (pending && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (pending) begin
      chk(0, req, "watchdog: no done", 0, 1);
      pending = 1'b0;
    end
    chk(txq.size() == 0, req, "bytes left unsent", txq.size(), 0);
    chk(rxq.size() == 0, req, "bytes left unread", rxq.size(), 0);
    repeat (3) @(negedge clk);
    chk(cs_n && !xfer_req, req, "idle after probe", {cs_n, xfer_req}, 2'b10);
  endtask

  initial begin
    h_found = 0; h_idx = 0; h_size = 0; h_addr = 0;
    e_found = 0; e_idx = 0; e_size = 0; e_addr = 0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
    chk(xfer_req == 1'b0, "R1", "req in reset", xfer_req, 0);
    chk(done == 1'b0 && found == 1'b0, "R1", "done/found in reset", {done, found}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 first table entry
    rxq = '{8'hC2, 8'h22, 8'h00}; set_tx(3, 0);
    run("R4", 1, 0, 32768, 2, 0);
    // R3 two continuation bytes then R4 last entry
    rxq = '{8'h7F, 8'h7F, 8'hC2, 8'h24, 8'h01}; set_tx(5, 0);
    run("R3", 1, 5, 131072, 3, 0);
    // R4 middle entries
    rxq = '{8'hC2, 8'h23, 8'h01}; set_tx(3, 0);
    run("R4", 1, 3, 65536, 2, 0);
    rxq = '{8'hC2, 8'h24, 8'h00}; set_tx(3, 0);
    run("R4", 1, 4, 131072, 3, 0);
    // R5 unknown pairs
    rxq = '{8'hC2, 8'h25, 8'h00}; set_tx(3, 0);
    run("R5", 0, 0, 0, 0, 0);
    rxq = '{8'hC2, 8'h22, 8'h02}; set_tx(3, 0);
    run("R5", 0, 0, 0, 0, 0);
    // R6 foreign manufacturer closes frame after one byte
    rxq = '{8'h1F}; set_tx(1, 0);
    run("R6", 0, 0, 0, 0, 0);
    // R3 exactly MAX_CONT continuation bytes is still accepted
    rxq = '{8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'hC2, 8'h23, 8'h00};
    set_tx(11, 0);
    run("R3", 1, 2, 65536, 2, 0);
    // R3 one more continuation byte fails
    rxq = '{8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F};
    set_tx(9, 0);
    run("R3", 0, 0, 0, 0, 0);
    // R7/R8 fallback accepted: status 0x8C has bits 5,4,0 clear
    rxq = '{8'hFF, 8'h8C}; set_tx(1, 1);
    run("R8", 1, 6, 262144, 3, 0);
    // R8 rejected by bit 4 and by bit 0
    rxq = '{8'hFF, 8'h10}; set_tx(1, 1);
    run("R8", 0, 0, 0, 0, 0);
    rxq = '{8'hFF, 8'h01}; set_tx(1, 1);
    run("R8", 0, 0, 0, 0, 0);
    // R10 start during a probe changes nothing
    rxq = '{8'h7F, 8'hC2, 8'h22, 8'h01}; set_tx(4, 0);
    run("R10", 1, 1, 32768, 2, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R9", "global watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule